// File: doc/BRIEF.md
# Temperature Sensor Register Bank with Pointer

This block holds the programmable state of a temperature monitor that sits on a two-wire serial bus. A separate bit-level protocol engine recovers bytes from the wire. It passes the device address, frame boundaries, write bytes and read requests to this block. The block decides whether the device address selects it, keeps a write-only pointer, and stores the configuration and the three trip limits with their power-on values. It also builds the read data for the capability, configuration, trip and live temperature registers.

Within a frame, the first written byte sets the pointer. The next two bytes form a 16-bit word, most significant byte first, and the word is committed only when its second byte arrives. Reads return the selected register one byte at a time. They start with the high byte and then alternate. The comparison logic sits outside the block. It receives the stored limits and configuration on dedicated outputs, and it returns the live temperature and its three flags as inputs.

Two lock bits in the configuration register protect the limits. One covers the alarm window and the other covers the critical limit. While either lock bit is set, the event mode and polarity bits cannot change. Once set, a lock bit stays set until reset.

Top module: `tsr_regfile`

## Requirements
- R1: `addr_hit_o` is high exactly when `hdr_addr_i` equals the nibble 0011 followed by `strap_i[2:0]`, with strap bit 2 the most significant of the three.
- R2: After reset the pointer selects code 0. Capability reads 0x0001 with default parameters, and configuration, upper, lower and critical limits read 0x0000.
- R3: The first byte written after `frame_start_i` is the pointer, and it persists across frames. Pointer codes are 0 capability, 1 configuration, 2 upper limit, 3 lower limit, 4 critical limit and 5 temperature. A pointer byte whose bits 7:3 are nonzero, or whose code is 6 or 7, reads 0x0000, and data written through it is dropped.
- R4: Each `rd_req_i` produces `rd_vld_o` with a data byte on the next cycle. The first read in a frame returns bits 15:8, and later reads alternate between the low and high byte.
- R5: A register changes only when the second data byte of a write arrives. A frame that ends after one data byte leaves every register unchanged, and bytes after the second data byte are ignored.
- R6: Writes to capability (code 0) and temperature (code 5) have no effect.
- R7: The trip registers (codes 2, 3, 4) store only bits 12:2. Bits 15:13 and 1:0 always read zero.
- R8: In the configuration register, bits 15:11 read zero and bit 4 reads `evt_state_i`; writes to these bits are ignored. Bits 10:8, 7:5 and 3:0 are stored.
- R9: While configuration bit 6 is set, writes to the upper and lower limits are dropped. While bit 7 is set, writes to the critical limit are dropped.
- R10: While configuration bit 6 or bit 7 is set, bits 1:0 (event mode and polarity) keep their value through configuration writes.
- R11: Configuration bits 6 and 7 cannot be cleared by a write; only reset clears them.
- R12: The temperature register reads the critical flag in bit 15, the above-window flag in bit 14, the below-window flag in bit 13, and `temp_i` in bits 12:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 3 | Board strap bits forming the low address bits |
| hdr_addr_i | input | 7 | Device address received by the protocol engine |
| addr_hit_o | output | 1 | Device address selects this block |
| frame_start_i | input | 1 | Pulse: new frame addressed to this block |
| frame_stop_i | input | 1 | Pulse: frame ended |
| wr_vld_i | input | 1 | Pulse: write byte valid |
| wr_byte_i | input | 8 | Write byte |
| rd_req_i | input | 1 | Pulse: next read byte requested |
| rd_vld_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |
| temp_i | input | 13 | Live temperature value |
| crit_flag_i | input | 1 | Temperature above critical limit |
| hi_flag_i | input | 1 | Temperature above window |
| lo_flag_i | input | 1 | Temperature below window |
| evt_state_i | input | 1 | Current event output status |
| cfg_o | output | 16 | Stored configuration bits |
| hi_lim_o | output | 16 | Upper window limit |
| lo_lim_o | output | 16 | Lower window limit |
| crit_lim_o | output | 16 | Critical limit |

## Verification
The hardest state to reach is a locked configuration in which a later configuration write tries to clear the locks, alter mode and polarity, and change unrelated fields in the same word. The stimulus first commits a configuration that sets the window lock and a new mode in one write, which the old unlocked state allows. It then writes all-zero and critical-lock words. Each write is followed by a read to show that only the unprotected fields moved. Aborted frames, out-of-range pointers and trailing bytes are also driven. Each of them is followed by a pointer-less read that shows the stored pointer and the untouched data.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic [1:0] {
    WP_PTR  = 2'd0,
    WP_MSB  = 2'd1,
    WP_LSB  = 2'd2,
    WP_IDLE = 2'd3
  } wr_phase_e;

  localparam logic [2:0] SEL_CAP  = 3'd0;
  localparam logic [2:0] SEL_CFG  = 3'd1;
  localparam logic [2:0] SEL_HI   = 3'd2;
  localparam logic [2:0] SEL_LO   = 3'd3;
  localparam logic [2:0] SEL_CRIT = 3'd4;
  localparam logic [2:0] SEL_TEMP = 3'd5;

  localparam int CFG_MODE  = 0;
  localparam int CFG_POL   = 1;
  localparam int CFG_STAT  = 4;
  localparam int CFG_LOCKW = 6;
  localparam int CFG_LOCKC = 7;
endpackage

// File: rtl/tsr_addr_match.sv
module tsr_addr_match #(
  parameter int          STRAP_W = 3,
  parameter int          ADDR_W  = 7,
  parameter logic [ADDR_W-STRAP_W-1:0] BASE = 4'b0011
) (
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               hit_o
);
  logic [ADDR_W-1:0] own_addr;

  assign own_addr = {BASE, strap_i};
  assign hit_o    = (addr_i == own_addr);
endmodule

// File: rtl/tsr_byte_seq.sv
module tsr_byte_seq
  import tsr_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int NUM_REGS = 6,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              frame_stop_i,
  input  logic              wr_vld_i,
  input  logic [7:0]        wr_byte_i,
  input  logic              rd_req_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              sel_ok_o,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o,
  output logic              rd_low_o
);
  wr_phase_e        phase_q, phase_d;
  logic [SEL_W-1:0] ptr_q, ptr_d;
  logic             ok_q, ok_d;
  logic [7:0]       msb_q, msb_d;
  logic             low_q, low_d;
  logic             commit;

  always_comb begin
    phase_d = phase_q;
    ptr_d   = ptr_q;
    ok_d    = ok_q;
    msb_d   = msb_q;
    low_d   = low_q;
    commit  = 1'b0;
    if (frame_start_i) begin
      phase_d = WP_PTR;
      low_d   = 1'b0;
    end else begin
      if (wr_vld_i) begin
        case (phase_q)
          WP_PTR: begin
            ptr_d   = wr_byte_i[SEL_W-1:0];
            ok_d    = (wr_byte_i[7:SEL_W] == '0) &&
                      (int'(wr_byte_i[SEL_W-1:0]) < NUM_REGS);
            phase_d = WP_MSB;
          end
          WP_MSB: begin
            msb_d   = wr_byte_i;
            phase_d = WP_LSB;
          end
          WP_LSB: begin
            commit  = 1'b1;
            phase_d = WP_IDLE;
          end
          default: phase_d = WP_IDLE;
        endcase
      end
      if (frame_stop_i) phase_d = WP_IDLE;
      if (rd_req_i)     low_d   = ~low_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= WP_IDLE;
      ptr_q   <= '0;
      ok_q    <= 1'b1;
      msb_q   <= '0;
      low_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ptr_q   <= ptr_d;
      ok_q    <= ok_d;
      msb_q   <= msb_d;
      low_q   <= low_d;
    end
  end

  assign sel_o    = ptr_q;
  assign sel_ok_o = ok_q;
  assign commit_o = commit;
  assign word_o   = {msb_q, wr_byte_i};
  assign rd_low_o = low_q;
endmodule

// File: rtl/tsr_regs.sv
module tsr_regs
  import tsr_pkg::*;
#(
  parameter int                WORD_W    = 16,
  parameter logic [WORD_W-1:0] TRIP_MASK = 16'h1FFC,
  parameter logic [WORD_W-1:0] CFG_WMASK = 16'h07EF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [2:0]        sel_i,
  input  logic              sel_ok_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] cfg_o,
  output logic [WORD_W-1:0] hi_o,
  output logic [WORD_W-1:0] lo_o,
  output logic [WORD_W-1:0] crit_o
);
  localparam int NUM_TRIP = 3;

  logic [WORD_W-1:0] cfg_q, cfg_d;
  logic              cfg_en;
  logic              any_lock;
  logic [WORD_W-1:0] trip_q [NUM_TRIP];

  assign any_lock = cfg_q[CFG_LOCKW] | cfg_q[CFG_LOCKC];
  assign cfg_en   = commit_i && sel_ok_i && (sel_i == SEL_CFG);

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_en) begin
      cfg_d            = word_i & CFG_WMASK;
      cfg_d[CFG_LOCKW] = word_i[CFG_LOCKW] | cfg_q[CFG_LOCKW];
      cfg_d[CFG_LOCKC] = word_i[CFG_LOCKC] | cfg_q[CFG_LOCKC];
      if (any_lock) begin
        cfg_d[CFG_MODE] = cfg_q[CFG_MODE];
        cfg_d[CFG_POL]  = cfg_q[CFG_POL];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  for (genvar i = 0; i < NUM_TRIP; i++) begin : g_trip
    logic              locked;
    logic              hit;
    logic [WORD_W-1:0] d;
    logic [WORD_W-1:0] q;

    assign locked = (i < 2) ? cfg_q[CFG_LOCKW] : cfg_q[CFG_LOCKC];
    assign hit    = commit_i && sel_ok_i && !locked &&
                    (sel_i == SEL_HI + 3'(i));

    always_comb begin
      d = q;
      if (hit) d = word_i & TRIP_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign trip_q[i] = q;
  end

  assign cfg_o  = cfg_q;
  assign hi_o   = trip_q[0];
  assign lo_o   = trip_q[1];
  assign crit_o = trip_q[2];
endmodule

// File: rtl/tsr_regfile.sv
module tsr_regfile
  import tsr_pkg::*;
#(
  parameter int         WORD_W  = 16,
  parameter int         STRAP_W = 3,
  parameter logic [1:0] RES_SEL = 2'b00,
  parameter logic       WIDE_RANGE = 1'b0,
  parameter logic       HI_PREC = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [6:0]        hdr_addr_i,
  output logic              addr_hit_o,
  input  logic              frame_start_i,
  input  logic              frame_stop_i,
  input  logic              wr_vld_i,
  input  logic [7:0]        wr_byte_i,
  input  logic              rd_req_i,
  output logic              rd_vld_o,
  output logic [7:0]        rd_data_o,
  input  logic [WORD_W-4:0] temp_i,
  input  logic              crit_flag_i,
  input  logic              hi_flag_i,
  input  logic              lo_flag_i,
  input  logic              evt_state_i,
  output logic [WORD_W-1:0] cfg_o,
  output logic [WORD_W-1:0] hi_lim_o,
  output logic [WORD_W-1:0] lo_lim_o,
  output logic [WORD_W-1:0] crit_lim_o
);
  localparam int NUM_REGS = 6;
  localparam int SEL_W    = 3;

  logic [1:0]        rst_sync;
  logic              rst_q;
  logic [SEL_W-1:0]  sel;
  logic              sel_ok;
  logic              commit;
  logic [WORD_W-1:0] word;
  logic              rd_low;
  logic [WORD_W-1:0] cap_word, cfg_word, temp_word, rd_word;
  logic [7:0]        rd_byte;
  logic              rd_take;
  logic              rd_vld_q, rd_vld_d;
  logic [7:0]        rd_data_q, rd_data_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  tsr_addr_match #(.STRAP_W(STRAP_W), .ADDR_W(7), .BASE(4'b0011)) u_match (
    .strap_i (strap_i),
    .addr_i  (hdr_addr_i),
    .hit_o   (addr_hit_o)
  );

  tsr_byte_seq #(.SEL_W(SEL_W), .NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_q),
    .frame_start_i (frame_start_i),
    .frame_stop_i  (frame_stop_i),
    .wr_vld_i      (wr_vld_i),
    .wr_byte_i     (wr_byte_i),
    .rd_req_i      (rd_req_i),
    .sel_o         (sel),
    .sel_ok_o      (sel_ok),
    .commit_o      (commit),
    .word_o        (word),
    .rd_low_o      (rd_low)
  );

  tsr_regs #(.WORD_W(WORD_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_q),
    .commit_i (commit),
    .sel_i    (sel),
    .sel_ok_i (sel_ok),
    .word_i   (word),
    .cfg_o    (cfg_o),
    .hi_o     (hi_lim_o),
    .lo_o     (lo_lim_o),
    .crit_o   (crit_lim_o)
  );

  assign cap_word  = {{(WORD_W-5){1'b0}}, RES_SEL, WIDE_RANGE, HI_PREC, 1'b1};
  assign temp_word = {crit_flag_i, hi_flag_i, lo_flag_i, temp_i};

  always_comb begin
    cfg_word           = cfg_o;
    cfg_word[CFG_STAT] = evt_state_i;
  end

  always_comb begin
    rd_word = '0;
    if (sel_ok) begin
      case (sel)
        SEL_CAP:  rd_word = cap_word;
        SEL_CFG:  rd_word = cfg_word;
        SEL_HI:   rd_word = hi_lim_o;
        SEL_LO:   rd_word = lo_lim_o;
        SEL_CRIT: rd_word = crit_lim_o;
        SEL_TEMP: rd_word = temp_word;
        default:  rd_word = '0;
      endcase
    end
  end

  assign rd_byte = rd_low ? rd_word[7:0] : rd_word[WORD_W-1:WORD_W-8];
  assign rd_take = rd_req_i && !frame_start_i;

  always_comb begin
    rd_vld_d  = rd_take;
    rd_data_d = rd_data_q;
    if (rd_take) rd_data_d = rd_byte;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_vld_q  <= rd_vld_d;
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_vld_o  = rd_vld_q;
  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/tsr_regfile_chk.sv
module tsr_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  strap_i,
  input logic [6:0]  hdr_addr_i,
  input logic        addr_hit_o,
  input logic        frame_start_i,
  input logic        rd_req_i,
  input logic        rd_vld_o,
  input logic [15:0] cfg_o,
  input logic [15:0] hi_lim_o,
  input logic [15:0] lo_lim_o,
  input logic [15:0] crit_lim_o
);
  a_r1_addr_hit: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit_o == (hdr_addr_i == {4'b0011, strap_i}));

  a_r4_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !frame_start_i) |=> rd_vld_o);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_i && !frame_start_i) |=> !rd_vld_o);

  a_r7_trip_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_lim_o | lo_lim_o | crit_lim_o) & 16'hE003) == 16'h0000);

  a_r8_cfg_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[15:11] == 5'd0 && cfg_o[4] == 1'b0);

  a_r9_window_lock: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[6] |=> ($stable(hi_lim_o) && $stable(lo_lim_o)));

  a_r9_crit_lock: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[7] |=> $stable(crit_lim_o));

  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o[6] || cfg_o[7]) |=> $stable(cfg_o[1:0]));

  a_r11_lockw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[6] |=> cfg_o[6]);

  a_r11_lockc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[7] |=> cfg_o[7]);
endmodule

bind tsr_regfile tsr_regfile_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_q),
  .strap_i       (strap_i),
  .hdr_addr_i    (hdr_addr_i),
  .addr_hit_o    (addr_hit_o),
  .frame_start_i (frame_start_i),
  .rd_req_i      (rd_req_i),
  .rd_vld_o      (rd_vld_o),
  .cfg_o         (cfg_o),
  .hi_lim_o      (hi_lim_o),
  .lo_lim_o      (lo_lim_o),
  .crit_lim_o    (crit_lim_o)
);

// File: tb/tsr_regfile_tb.sv
module tsr_regfile_tb;
  localparam logic [1:0] OP_S = 2'd0;
  localparam logic [1:0] OP_W = 2'd1;
  localparam logic [1:0] OP_R = 2'd2;
  localparam logic [1:0] OP_P = 2'd3;
  localparam int NVEC = 49;

  // entry: {op, write data, expected read byte}; rows cover R2 R4 R5 R6 R7
  localparam logic [17:0] VEC [NVEC] = '{
    {OP_S, 8'h00, 8'h00}, {OP_R, 8'h00, 8'h00}, {OP_R, 8'h00, 8'h01}, {OP_P, 8'h00, 8'h00},
    {OP_S, 8'h00, 8'h00}, {OP_W, 8'h01, 8'h00}, {OP_P, 8'h00, 8'h00},
    {OP_S, 8'h00, 8'h00}, {OP_R, 8'h00, 8'h00}, {OP_R, 8'h00, 8'h00}, {OP_P, 8'h00, 8'h00},
    {OP_S, 8'h00, 8'h00}, {OP_W, 8'h02, 8'h00}, {OP_W, 8'hFF, 8'h00}, {OP_W, 8'hFF, 8'h00},
    {OP_P, 8'h00, 8'h00},
    {OP_S, 8'h00, 8'h00}, {OP_R, 8'h00, 8'h1F}, {OP_R, 8'h00, 8'hFC}, {OP_P, 8'h00, 8'h00},
    {OP_S, 8'h00, 8'h00}, {OP_W, 8'h03, 8'h00}, {OP_W, 8'h01, 8'h00}, {OP_W, 8'h23, 8'h00},
    {OP_P, 8'h00, 8'h00},
    {OP_S, 8'h00, 8'h00}, {OP_R, 8'h00, 8'h01}, {OP_R, 8'h00, 8'h20}, {OP_P, 8'h00, 8'h00},
    {OP_S, 8'h00, 8'h00}, {OP_W, 8'h04, 8'h00}, {OP_W, 8'h05, 8'h00}, {OP_W, 8'h50, 8'h00},
    {OP_W, 8'h0F, 8'h00}, {OP_W, 8'hFC, 8'h00}, {OP_P, 8'h00, 8'h00},
    {OP_S, 8'h00, 8'h00}, {OP_R, 8'h00, 8'h05}, {OP_R, 8'h00, 8'h50}, {OP_P, 8'h00, 8'h00},
    {OP_S, 8'h00, 8'h00}, {OP_W, 8'h00, 8'h00}, {OP_W, 8'hFF, 8'h00}, {OP_W, 8'hFF, 8'h00},
    {OP_P, 8'h00, 8'h00},
    {OP_S, 8'h00, 8'h00}, {OP_R, 8'h00, 8'h00}, {OP_R, 8'h00, 8'h01}, {OP_P, 8'h00, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  strap_i = 3'd0;
  logic [6:0]  hdr_addr_i = 7'd0;
  logic        addr_hit_o;
  logic        frame_start_i = 1'b0;
  logic        frame_stop_i = 1'b0;
  logic        wr_vld_i = 1'b0;
  logic [7:0]  wr_byte_i = 8'd0;
  logic        rd_req_i = 1'b0;
  logic        rd_vld_o;
  logic [7:0]  rd_data_o;
  logic [12:0] temp_i = 13'd0;
  logic        crit_flag_i = 1'b0;
  logic        hi_flag_i = 1'b0;
  logic        lo_flag_i = 1'b0;
  logic        evt_state_i = 1'b0;
  logic [15:0] cfg_o, hi_lim_o, lo_lim_o, crit_lim_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  tsr_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .hdr_addr_i(hdr_addr_i),
    .addr_hit_o(addr_hit_o), .frame_start_i(frame_start_i), .frame_stop_i(frame_stop_i),
    .wr_vld_i(wr_vld_i), .wr_byte_i(wr_byte_i), .rd_req_i(rd_req_i),
    .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o), .temp_i(temp_i),
    .crit_flag_i(crit_flag_i), .hi_flag_i(hi_flag_i), .lo_flag_i(lo_flag_i),
    .evt_state_i(evt_state_i), .cfg_o(cfg_o), .hi_lim_o(hi_lim_o),
    .lo_lim_o(lo_lim_o), .crit_lim_o(crit_lim_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic op(input logic [1:0] kind, input logic [7:0] data,
                    output logic [7:0] got, output logic vld);
    frame_start_i = (kind == OP_S);
    wr_vld_i      = (kind == OP_W);
    wr_byte_i     = data;
    rd_req_i      = (kind == OP_R);
    frame_stop_i  = (kind == OP_P);
    @(negedge clk);
    got = rd_data_o;
    vld = rd_vld_o;
    frame_start_i = 1'b0;
    wr_vld_i      = 1'b0;
    rd_req_i      = 1'b0;
    frame_stop_i  = 1'b0;
  endtask

  task automatic wr16(input logic [7:0] ptr, input logic [15:0] val);
    logic [7:0] g; logic v;
    op(OP_S, 8'h00, g, v);
    op(OP_W, ptr, g, v);
    op(OP_W, val[15:8], g, v);
    op(OP_W, val[7:0], g, v);
    op(OP_P, 8'h00, g, v);
  endtask

  task automatic rd_cur(output logic [15:0] val);
    logic [7:0] g; logic v;
    op(OP_S, 8'h00, g, v);
    op(OP_R, 8'h00, g, v);
    val[15:8] = v ? g : 8'hXX;
    op(OP_R, 8'h00, g, v);
    val[7:0] = v ? g : 8'hXX;
    op(OP_P, 8'h00, g, v);
  endtask

  task automatic rd16(input logic [7:0] ptr, output logic [15:0] val);
    logic [7:0] g; logic v;
    op(OP_S, 8'h00, g, v);
    op(OP_W, ptr, g, v);
    op(OP_P, 8'h00, g, v);
    rd_cur(val);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [7:0]  g;
    logic        v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 reset cfg_o", cfg_o, 16'h0000);
    chk("R4 no read valid after reset", rd_vld_o, 0);

    for (int i = 0; i < NVEC; i++) begin
      op(VEC[i][17:16], VEC[i][15:8], g, v);
      if (VEC[i][17:16] == OP_R) begin
        checks++;
        if (!v || g !== VEC[i][7:0]) begin
          errors++;
          $display("FAIL table row %0d (R2 R4 R5 R6 R7): got vld=%0b 0x%0h expected 0x%0h",
                   i, v, g, VEC[i][7:0]);
        end
      end
    end

    // R12 temperature layout
    temp_i = 13'h0195; crit_flag_i = 1'b1; hi_flag_i = 1'b0; lo_flag_i = 1'b1;
    rd16(8'h05, w); chk("R12 temp flags 101", w, 16'hA195);
    temp_i = 13'h1FFF; crit_flag_i = 1'b0; hi_flag_i = 1'b1; lo_flag_i = 1'b0;
    rd_cur(w); chk("R12 temp flags 010", w, 16'h5FFF);
    // R6 temperature write ignored
    wr16(8'h05, 16'h0000);
    rd_cur(w); chk("R6 temp write ignored", w, 16'h5FFF);

    // R5 aborted write after one data byte; R3 pointer persists
    op(OP_S, 8'h00, g, v); op(OP_W, 8'h03, g, v); op(OP_W, 8'h77, g, v); op(OP_P, 8'h00, g, v);
    rd_cur(w); chk("R5 half write dropped / R3 pointer kept", w, 16'h0120);

    // R3 invalid pointers
    wr16(8'h06, 16'h1234);
    rd16(8'h06, w); chk("R3 code 6 reads zero", w, 16'h0000);
    wr16(8'h0A, 16'h0400);
    rd16(8'h0A, w); chk("R3 upper pointer bits read zero", w, 16'h0000);
    rd16(8'h02, w); chk("R3 write through bad pointer dropped", w, 16'h1FFC);

    // R8 configuration fields
    evt_state_i = 1'b0;
    wr16(8'h01, 16'h0703);
    rd16(8'h01, w); chk("R8 cfg stored bits", w, 16'h0703);
    evt_state_i = 1'b1;
    rd_cur(w); chk("R8 cfg bit4 follows event status", w, 16'h0713);
    evt_state_i = 1'b0;
    wr16(8'h01, 16'hF810);
    rd_cur(w); chk("R8 cfg reserved and status not writable", w, 16'h0000);

    // R9 R10 R11 locks
    wr16(8'h01, 16'h0343);
    rd_cur(w); chk("R10 lock and mode set together", w, 16'h0343);
    wr16(8'h02, 16'h0100);
    rd16(8'h02, w); chk("R9 upper blocked by window lock", w, 16'h1FFC);
    wr16(8'h03, 16'h0040);
    rd16(8'h03, w); chk("R9 lower blocked by window lock", w, 16'h0120);
    wr16(8'h04, 16'h0200);
    rd16(8'h04, w); chk("R9 critical writable without its lock", w, 16'h0200);
    wr16(8'h01, 16'h0000);
    rd16(8'h01, w); chk("R11 lock sticky / R10 mode frozen", w, 16'h0043);
    wr16(8'h01, 16'h0080);
    rd_cur(w); chk("R11 critical lock set", w, 16'h00C3);
    wr16(8'h04, 16'h0300);
    rd16(8'h04, w); chk("R9 critical blocked by its lock", w, 16'h0200);
    chk("R9 critical limit output", crit_lim_o, 16'h0200);

    // R1 address match
    strap_i = 3'b101; hdr_addr_i = 7'h1D; #1;
    chk("R1 own address hit", addr_hit_o, 1);
    hdr_addr_i = 7'h1C; #1;
    chk("R1 strap mismatch", addr_hit_o, 0);
    hdr_addr_i = 7'h5D; #1;
    chk("R1 base mismatch", addr_hit_o, 0);
    strap_i = 3'b000; hdr_addr_i = 7'h18; #1;
    chk("R1 strap zero hit", addr_hit_o, 1);
    @(negedge clk);

    // R2 reset clears locks and restores pointer; R4 third read wraps to MSB
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 cfg after reset", cfg_o, 16'h0000);
    chk("R2 critical after reset", crit_lim_o, 16'h0000);
    op(OP_S, 8'h00, g, v);
    op(OP_R, 8'h00, g, v); chk("R4 first byte MSB", {v, g}, 9'h100);
    op(OP_R, 8'h00, g, v); chk("R4 second byte LSB", {v, g}, 9'h101);
    op(OP_R, 8'h00, g, v); chk("R4 third byte MSB again", {v, g}, 9'h100);
    op(OP_P, 8'h00, g, v);
    chk("R4 valid drops without request", rd_vld_o, 0);
    wr16(8'h02, 16'h0400);
    rd16(8'h02, w); chk("R2 lock cleared by reset", w, 16'h0400);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule